// File: doc/BRIEF.md
# Stack frame save/restore sequencer

This block runs the compressed stack-frame instructions that save or restore a group of registers. It takes the instruction in one of two forms: a 16-bit base halfword, or that halfword with a 16-bit prefix in front of it. From the instruction it works out which registers take part, in what order they go, and how big the frame is. It then moves the selected registers between the register file and memory, one word per access. It finishes by writing the updated stack pointer (r29).

The pipeline pulses `start_i` with the instruction word while the block is idle. The block reads the stack pointer through its register-file read port. It then walks a fixed list of up to eighteen transfer slots. It issues one memory request at a time and holds each request until `mem_ack_i`. On a save, the data to store comes from the register-file read port. On a restore, each returned word is sign-extended and written back into the register file. A one-cycle `done_o` pulse ends the operation. An unusable argument code raises `error_o` with that pulse, and in that case no access is made.

Top module: `stack_frame_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `error_o`, `mem_req_o` and `rf_we_o` are all low.
- R2: Base-only form (`ext_i`=0): `insn_i[7]` selects save (1) or restore (0). `insn_i[6:4]` selects registers: bit 2 is r31, bit 1 is r16, bit 0 is r17. The frame size is `insn_i[3:0]`×8 bytes, or 128 bytes when that field is zero. The count of saved high registers and the argument code both act as zero.
- R3: Prefixed form (`ext_i`=1) uses prefix fields `insn_i[26:24]` (count of high saved registers), `insn_i[23:20]` (upper frame nibble) and `insn_i[19:16]` (argument code). The frame size is {`insn_i[23:20]`,`insn_i[3:0]`}×8 bytes.
- R4: On a save, the argument code gives a count of ascending stores: code 4–7 gives 1, 8–10 gives 2, 12–13 gives 3, 14 gives 4, and every other code gives 0. These stores write r4, r5, r6 and r7, in that order, to SP+0, SP+4, SP+8 and SP+12, up to the count.
- R5: Next come descending accesses, each at the previous address minus 4, starting from the base address. The order is: r31 if selected; then, for a high count n, the last n entries of the list r30, r23, r22, r21, r20, r19, r18; then r17 if selected; then r16 if selected.
- R6: After those, the argument code gives a count of descending accesses to r7, r6, r5 and r4, in that order. Codes 1, 5, 9 and 13 give 1; codes 2, 6 and 10 give 2; codes 3 and 7 give 3; code 11 gives 4; every other code gives 0.
- R7: A save uses the old SP as the descending base and ends by writing SP minus the frame size to r29.
- R8: A restore makes no ascending stores. It loads in the R5/R6 order from a base of SP plus the frame size. Each loaded word is sign-extended to register width. The restore ends by writing SP plus the frame size to r29.
- R9: A prefixed instruction with argument code 15 pulses `done_o` together with `error_o`. It makes no memory request and writes no register.
- R10: At most one memory request is outstanding at a time. While `mem_ack_i` is low, the request, its address and its direction hold steady.
- R11: `busy_o` rises the cycle after an accepted start and stays high until the cycle in which `done_o` pulses, when it drops. A start that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| ext_i | input | 1 | 1 when `insn_i[31:16]` holds a valid prefix |
| insn_i | input | 32 | Prefix halfword in [31:16], base halfword in [15:0] |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Unusable argument code; valid together with `done_o` |
| rf_raddr_o | output | 5 | Register-file read address |
| rf_rdata_i | input | XLEN | Register-file read data, same cycle |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write address |
| rf_wdata_o | output | XLEN | Register-file write data |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | 1 for store, 0 for load |
| mem_addr_o | output | XLEN | Word byte address |
| mem_wdata_o | output | 32 | Store data |
| mem_ack_i | input | 1 | Request accepted; load data valid |
| mem_rdata_i | input | 32 | Load data |

## Verification
The bench aims at the ordering seams. It uses argument codes that split between the ascending and descending groups (7, 9, 11, 14). It uses high-register count 7, which is the only count that brings in r30. It uses the zero frame field, which means 128 bytes in the base form and zero in the prefixed form. A design with the count tables mixed up would store the wrong register at the wrong address. A design that dropped the pre-decrement, or that restored from the old SP, would show up in the first address it issued. Code 15 has to finish with no access at all. The bench loads words with bit 31 set, so a restore that zero-extends leaves wrong upper halves. A second start sent in mid-operation must not alter the access stream. Memory latency varies from access to access, so a design that steps forward without an acknowledge would skip slots.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int SLOTS  = 18;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int SP_REG = 29;
  localparam int ARG_SLOTS = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SPRD, ST_XFER, ST_SPWR} state_t;

  // register carried by each transfer slot, in issue order
  function automatic logic [4:0] slot_reg(input logic [SLOT_W-1:0] s);
    logic [4:0] r;
    if (s < 5'd4)        r = 5'(5'd4 + s);          // ascending arguments r4..r7
    else if (s == 5'd4)  r = 5'd31;
    else if (s == 5'd5)  r = 5'd30;
    else if (s < 5'd12)  r = 5'(5'd29 - s);         // r23 .. r18
    else if (s == 5'd12) r = 5'd17;
    else if (s == 5'd13) r = 5'd16;
    else                 r = 5'(5'd21 - s);         // r7 .. r4 descending
    return r;
  endfunction

  function automatic logic [2:0] arg_count(input logic [3:0] a);
    logic [2:0] n;
    case (a)
      4'd4, 4'd5, 4'd6, 4'd7:   n = 3'd1;
      4'd8, 4'd9, 4'd10:        n = 3'd2;
      4'd12, 4'd13:             n = 3'd3;
      4'd14:                    n = 3'd4;
      default:                  n = 3'd0;
    endcase
    return n;
  endfunction

  function automatic logic [2:0] static_count(input logic [3:0] a);
    logic [2:0] n;
    case (a)
      4'd1, 4'd5, 4'd9, 4'd13:  n = 3'd1;
      4'd2, 4'd6, 4'd10:        n = 3'd2;
      4'd3, 4'd7:               n = 3'd3;
      4'd11:                    n = 3'd4;
      default:                  n = 3'd0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/sfs_decode.sv
module sfs_decode
  import sfs_pkg::*;
#(
  parameter int FRAME_W = 11
) (
  input  logic               ext_i,
  input  logic [31:0]        insn_i,
  output logic               save_o,
  output logic               bad_o,
  output logic [SLOTS-1:0]   mask_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic [2:0] ras, xs, nargs, nstat;
  logic [3:0] acode, flo, fhi;

  assign save_o = insn_i[7];
  assign ras    = insn_i[6:4];
  assign flo    = insn_i[3:0];
  assign xs     = ext_i ? insn_i[26:24] : 3'd0;
  assign fhi    = ext_i ? insn_i[23:20] : 4'd0;
  assign acode  = ext_i ? insn_i[19:16] : 4'd0;
  assign bad_o  = (acode == 4'hF);
  assign nargs  = arg_count(acode);
  assign nstat  = static_count(acode);

  always_comb begin
    if (!ext_i && flo == 4'd0) frame_o = FRAME_W'(128);
    else                       frame_o = FRAME_W'({fhi, flo, 3'b000});
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < ARG_SLOTS) begin : g_arg
      assign mask_o[g] = save_o && (3'(g) < nargs);
    end else if (g == 4) begin : g_ra
      assign mask_o[g] = ras[2];
    end else if (g < 12) begin : g_xs
      assign mask_o[g] = (xs >= 3'(12 - g));
    end else if (g == 12) begin : g_s1
      assign mask_o[g] = ras[0];
    end else if (g == 13) begin : g_s0
      assign mask_o[g] = ras[1];
    end else begin : g_stat
      assign mask_o[g] = (3'(g - 14) < nstat);
    end
  end
endmodule

// File: rtl/sfs_pick.sv
module sfs_pick
  import sfs_pkg::*;
(
  input  logic [SLOTS-1:0]  mask_i,
  output logic [SLOT_W-1:0] idx_o,
  output logic [SLOTS-1:0]  rest_o
);
  always_comb begin
    idx_o = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (mask_i[i]) idx_o = SLOT_W'(i);
    rest_o = mask_i & ~(SLOTS'(1) << idx_o);
  end
endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
  import sfs_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int FRAME_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            ext_i,
  input  logic [31:0]     insn_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            error_o,
  output logic [4:0]      rf_raddr_o,
  input  logic [XLEN-1:0] rf_rdata_i,
  output logic            rf_we_o,
  output logic [4:0]      rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [31:0]     mem_rdata_i
);
  state_t              state_q;
  logic                save_q, bad_q, done_q, err_q;
  logic [SLOTS-1:0]    mask_q;
  logic [FRAME_W-1:0]  frame_q;
  logic [XLEN-1:0]     sp_q, dptr_q;

  logic                dec_save, dec_bad;
  logic [SLOTS-1:0]    dec_mask, rest;
  logic [FRAME_W-1:0]  dec_frame;
  logic [SLOT_W-1:0]   cur;
  logic [4:0]          cur_reg;
  logic                cur_up;
  logic [XLEN-1:0]     addr, new_sp, load_ext;

  sfs_decode #(.FRAME_W(FRAME_W)) u_dec (
    .ext_i(ext_i), .insn_i(insn_i), .save_o(dec_save), .bad_o(dec_bad),
    .mask_o(dec_mask), .frame_o(dec_frame)
  );

  sfs_pick u_pick (.mask_i(mask_q), .idx_o(cur), .rest_o(rest));

  assign cur_reg = slot_reg(cur);
  assign cur_up  = (cur < SLOT_W'(ARG_SLOTS));
  assign addr    = cur_up ? sp_q + XLEN'({cur, 2'b00}) : dptr_q - XLEN'(4);
  assign new_sp  = save_q ? sp_q - XLEN'(frame_q) : sp_q + XLEN'(frame_q);

  if (XLEN > 32) begin : g_sext
    assign load_ext = {{(XLEN-32){mem_rdata_i[31]}}, mem_rdata_i};
  end else begin : g_plain
    assign load_ext = mem_rdata_i[XLEN-1:0];
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign error_o     = err_q;
  assign mem_req_o   = (state_q == ST_XFER);
  assign mem_we_o    = save_q;
  assign mem_addr_o  = {addr[XLEN-1:2], 2'b00};
  assign mem_wdata_o = rf_rdata_i[31:0];
  assign rf_raddr_o  = (state_q == ST_SPRD) ? 5'(SP_REG) : cur_reg;
  assign rf_we_o     = (state_q == ST_SPWR) ||
                       (state_q == ST_XFER && mem_ack_i && !save_q);
  assign rf_waddr_o  = (state_q == ST_SPWR) ? 5'(SP_REG) : cur_reg;
  assign rf_wdata_o  = (state_q == ST_SPWR) ? new_sp : load_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      save_q  <= 1'b0;
      bad_q   <= 1'b0;
      mask_q  <= '0;
      frame_q <= '0;
      sp_q    <= '0;
      dptr_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          save_q  <= dec_save;
          bad_q   <= dec_bad;
          mask_q  <= dec_mask;
          frame_q <= dec_frame;
          state_q <= ST_SPRD;
        end
        ST_SPRD: begin
          sp_q   <= rf_rdata_i;
          dptr_q <= save_q ? rf_rdata_i : rf_rdata_i + XLEN'(frame_q);
          if (bad_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else if (mask_q == '0) begin
            state_q <= ST_SPWR;
          end else begin
            state_q <= ST_XFER;
          end
        end
        ST_XFER: if (mem_ack_i) begin
          mask_q <= rest;
          if (!cur_up) dptr_q <= dptr_q - XLEN'(4);
          if (rest == '0) state_q <= ST_SPWR;
        end
        default: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            error_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic            mem_ack_i,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            rf_we_o,
  input logic [4:0]      rf_waddr_o
);
  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R10
  req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> busy_o);

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !$past(done_o)));

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    error_o |-> done_o);

  // R9
  err_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    error_o |-> ($past(busy_o) && !$past(mem_req_o) && !$past(rf_we_o)));

  // R8
  load_write_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we_o && rf_waddr_o != 5'd29) |-> (mem_req_o && mem_ack_i && !mem_we_o));
endmodule

bind stack_frame_seq sfs_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .error_o(error_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o), .rf_we_o(rf_we_o),
  .rf_waddr_o(rf_waddr_o)
);

// File: tb/stack_frame_seq_test.sv
module stack_frame_seq_test;
  localparam int XL = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, ext = 1'b0;
  logic [31:0] insn = '0;
  logic busy, done, error;
  logic [4:0] rf_raddr, rf_waddr;
  logic [XL-1:0] rf_rdata, rf_wdata, mem_addr;
  logic rf_we, mem_req, mem_we;
  logic mem_ack = 1'b0;
  logic [31:0] mem_wdata, mem_rdata = '0;

  logic [XL-1:0] rf [32];
  logic [31:0] mem [int unsigned];
  int q_addr[$];
  int q_reg[$];
  bit q_we[$];
  logic [XL-1:0] exp_rf [32];
  bit exp_v [32];
  int checks = 0, fails = 0, cycles = 0, lat = 0, waitc = 0, nacc = 0;

  always #5 clk = ~clk;

  stack_frame_seq #(.XLEN(XL)) uut (
    .clk(clk), .rst(rst), .start_i(start), .ext_i(ext), .insn_i(insn),
    .busy_o(busy), .done_o(done), .error_o(error),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [XL-1:0] act, input logic [XL-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [XL-1:0] sx(input logic [31:0] w);
    return {{(XL-32){w[31]}}, w};
  endfunction

  // memory responder with varying latency; compares every accepted access
  always @(negedge clk) begin
    cycles++;
    if (mem_ack) begin
      mem_ack = 1'b0;
      waitc = 0;
    end else if (mem_req) begin
      if (waitc >= lat) begin
        if (q_addr.size() == 0) begin
          chk(1'b0, "R5", "unexpected access addr", mem_addr, '0);
        end else begin
          automatic int ea = q_addr.pop_front();
          automatic int er = q_reg.pop_front();
          automatic bit ew = q_we.pop_front();
          chk(mem_addr == XL'(unsigned'(ea)), "R5", "access address", mem_addr, XL'(unsigned'(ea)));
          chk(mem_we == ew, "R8", "access direction", XL'(mem_we), XL'(ew));
          if (ew) begin
            chk(mem_wdata == rf[er][31:0], "R4", "store data", XL'(mem_wdata), XL'(rf[er][31:0]));
            mem[unsigned'(ea)] = mem_wdata;
          end else begin
            mem_rdata = mem.exists(unsigned'(ea)) ? mem[unsigned'(ea)] : 32'h0;
            exp_rf[er] = sx(mem_rdata);
            exp_v[er] = 1'b1;
          end
        end
        mem_ack = 1'b1;
        nacc++;
        lat = nacc % 3;
      end else begin
        waitc++;
      end
    end
  end

  function automatic int n_arg(input int a);
    if (a >= 4 && a <= 7) return 1;
    if (a >= 8 && a <= 10) return 2;
    if (a == 12 || a == 13) return 3;
    if (a == 14) return 4;
    return 0;
  endfunction

  function automatic int n_stat(input int a);
    if (a == 11) return 4;
    if (a == 15 || a == 0 || a == 14) return 0;
    return a % 4;
  endfunction

  task automatic push(input int a, input int r, input bit w);
    q_addr.push_back(a); q_reg.push_back(r); q_we.push_back(w);
  endtask

  task automatic run(input bit ex, input bit sv, input int xs, input int fhi,
                     input int ar, input int ras, input int flo, input bit poke,
                     input string tag);
    int frame, sp0, down, espx;
    logic [XL-1:0] esp;
    bit bad, busy_ok, seen;
    int hi[7] = '{30, 23, 22, 21, 20, 19, 18};
    frame = ex ? ((fhi * 16 + flo) * 8) : (flo == 0 ? 128 : flo * 8);
    if (!ex) begin xs = 0; ar = 0; end
    bad = ex && ar == 15;
    sp0 = int'(rf[29][31:0]);
    q_addr.delete(); q_reg.delete(); q_we.delete();
    foreach (exp_v[i]) exp_v[i] = 1'b0;
    if (!bad) begin
      down = sv ? sp0 : sp0 + frame;
      if (sv) for (int i = 0; i < n_arg(ar); i++) push(sp0 + 4 * i, 4 + i, 1'b1);
      if (ras[2]) begin down -= 4; push(down, 31, sv); end
      for (int j = 7 - xs; j < 7; j++) begin down -= 4; push(down, hi[j], sv); end
      if (ras[0]) begin down -= 4; push(down, 17, sv); end
      if (ras[1]) begin down -= 4; push(down, 16, sv); end
      for (int k = 0; k < n_stat(ar); k++) begin down -= 4; push(down, 7 - k, sv); end
    end
    espx = bad ? sp0 : (sv ? sp0 - frame : sp0 + frame);
    esp = XL'(unsigned'(espx));
    @(negedge clk);
    ext = ex;
    insn = {5'b11110, 3'(xs), 4'(fhi), 4'(ar), 8'b01100100, sv, 3'(ras), 4'(flo)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11", {tag, " busy after start"}, XL'(busy), 1);
    busy_ok = 1'b1; seen = 1'b0;
    for (int c = 0; c < 400 && !seen; c++) begin
      @(negedge clk);
      if (poke && c == 3) begin
        insn = 32'hF7FF_64FF; ext = 1'b1; start = 1'b1;
      end else start = 1'b0;
      if (done) seen = 1'b1;
      else if (!busy) busy_ok = 1'b0;
    end
    start = 1'b0;
    chk(seen, "R11", {tag, " done seen"}, XL'(seen), 1);
    chk(busy_ok && !busy, "R11", {tag, " busy span"}, XL'(busy), 0);
    chk(error == bad, "R9", {tag, " error flag"}, XL'(error), XL'(bad));
    chk(q_addr.size() == 0, "R5", {tag, " accesses left"}, XL'(q_addr.size()), 0);
    chk(rf[29] == esp, sv ? "R7" : "R8", {tag, " final SP"}, rf[29], esp);
    for (int r = 0; r < 32; r++)
      if (exp_v[r]) chk(rf[r] == exp_rf[r], "R8", {tag, " restored reg"}, rf[r], exp_rf[r]);
    @(negedge clk);
  endtask

  initial begin
    for (int r = 0; r < 32; r++)
      rf[r] = {32'h0000_1000 + 32'(r), (r % 2 == 1) ? 32'h8000_0000 + 32'(r * 16) : 32'h0100_0000 + 32'(r)};
    rf[29] = 64'h0000_0000_0000_4000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !error && !mem_req && !rf_we, "R1", "reset outputs",
        XL'({busy, done, error, mem_req, rf_we}), 0);
    // R2 base save, zero frame field means 128 bytes
    run(1'b0, 1'b1, 0, 0, 0, 7, 0, 1'b0, "R2 base save");
    for (int r = 16; r < 32; r++) if (r != 29) rf[r] = '0;
    // R2 R8 base restore with sign extension
    run(1'b0, 1'b0, 0, 0, 0, 7, 0, 1'b0, "R2 base restore");
    // R3 R5 R6 prefixed save: high count 7, code 11
    run(1'b1, 1'b1, 7, 1, 11, 5, 2, 1'b0, "R3 save xs7 a11");
    for (int r = 4; r < 32; r++) if (r != 29) rf[r] = '0;
    run(1'b1, 1'b0, 7, 1, 11, 5, 2, 1'b0, "R8 restore xs7 a11");
    // R4 all four arguments ascending
    run(1'b1, 1'b1, 3, 0, 14, 2, 4, 1'b0, "R4 save a14");
    // R4 R6 mixed codes
    run(1'b1, 1'b1, 2, 2, 7, 1, 0, 1'b0, "R6 save a7");
    run(1'b1, 1'b1, 5, 0, 9, 4, 1, 1'b0, "R4 save a9");
    run(1'b1, 1'b0, 1, 0, 13, 3, 3, 1'b0, "R6 restore a13");
    // R3 prefixed form, zero frame, nothing selected
    run(1'b1, 1'b1, 0, 0, 0, 0, 0, 1'b0, "R3 empty");
    // R9 unusable code
    run(1'b1, 1'b1, 4, 3, 15, 7, 5, 1'b0, "R9 code15");
    // R10 R11 start while busy ignored
    run(1'b1, 1'b1, 6, 0, 5, 6, 6, 1'b1, "R11 poke");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    chk(1'b0, "R11", "watchdog expired", XL'(cycles), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule